// File: doc/BRIEF.md
# Switching Period Window Fault Detector

This block watches a digitized PWM level and times the interval between successive valid rising edges with a cycle counter. It raises a one-cycle fault pulse in two cases: when the next valid rising edge comes too soon, before 0.7 of a programmed nominal period, or when it does not come within 1.3 of that period. The first case catches over-frequency and the second catches missing pulses or a stopped primary. The nominal period is an input given in clock counts. The two limits are derived from it with integer arithmetic. Each one is rounded outward, so that the rounding widens the accepted window and never narrows it.

Switching edges ring, so every valid edge opens a blanking window. A rising edge opens the rise window and a falling edge opens the fall window. Each window has its own programmable length in clock counts. The system chooses these lengths to suit the switching frequency: longer at low frequency and shorter at high frequency. While either window is open, the block raises no fault, and any further edge is taken as ringing and ignored. As a result, only the first valid rising edge and the first valid falling edge of a switching cycle count.

A fault does not latch. The fault pulse is meant to turn off both gate drivers and discharge the soft-start outside this block. After a fault, the detector stops measuring until the next valid rising edge. That edge starts a new measurement without being judged itself, so operation resumes by itself once good pulses return.

Top module: `period_window_det`

## Requirements
- R1: While reset is asserted and after it is released, fault, blank_rise_act and blank_fall_act are 0. With no PWM edge after reset, no fault is ever raised.
- R2: A valid rising edge arriving P cycles after the previous valid rising edge raises no fault when short_limit <= P <= long_limit.
- R3: If no valid rising edge arrives within long_limit cycles, a fault is raised. Let the last valid rising edge be sampled at clock edge t0. The fault pulse then starts at clock edge t0+long_limit, unless a blanking window defers it.
- R4: A valid rising edge sampled P cycles after the previous one, with P < short_limit, makes fault go high at that same clock edge.
- R5: short_limit = floor(7*N/10) and long_limit = ceil(13*N/10), where N is nom_period.
- R6: A valid rising edge sampled at clock edge t drives blank_rise_act high for exactly blank_rise_len cycles, starting at edge t. A valid falling edge does the same for blank_fall_act with blank_fall_len. A length of 0 opens no window.
- R7: An edge is valid only when both windows are closed. A rising or falling edge seen while a window is open does not restart either window, does not restart the period measurement, and raises no fault.
- R8: No fault is raised while either blanking window is open. A long-period fault that falls due inside a window is raised at the first clock edge at which both windows are closed.
- R9: The first valid rising edge after reset or after a fault only starts a measurement and never raises a fault. After a fault, the next good edges resume normal checking.
- R10: fault is a pulse one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | Digitized PWM level, synchronous to clk |
| nom_period | input | CNT_W | Nominal switching period in clock cycles |
| blank_rise_len | input | BLK_W | Rise blanking window length in cycles |
| blank_fall_len | input | BLK_W | Fall blanking window length in cycles |
| fault | output | 1 | One-cycle period-window fault pulse |
| blank_rise_act | output | 1 | Rise blanking window is open |
| blank_fall_act | output | 1 | Fall blanking window is open |

## Verification
Suppose the period counter holds a wrong value, or restarts on a ringing edge. The fault pulse then moves by a cycle or more, or shows up or disappears at the short and long limits, so exact-cycle checks at P = limit and P = limit ± 1 catch it at the next valid rising edge. A wrong armed state shows at once: either the first edge after reset or after a fault is judged, or a later short period goes unflagged. A wrong blanking timer shows on the blanking flags within the window length, and also moves a deferred long-period fault by the same number of cycles.

// File: rtl/pwd_pkg.sv
package pwd_pkg;

  // Lower acceptance bound: floor(7N/10), rounded down so the window only widens.
  function automatic logic [31:0] window_low(input logic [31:0] n);
    return (n * 32'd7) / 32'd10;
  endfunction

  // Upper acceptance bound: ceil(13N/10), rounded up so the window only widens.
  function automatic logic [31:0] window_high(input logic [31:0] n);
    return (n * 32'd13 + 32'd9) / 32'd10;
  endfunction

endpackage

// File: rtl/pwd_edge_det.sv
module pwd_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic rise,
  output logic fall
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_in;
  end

  assign rise = level_in & ~level_q;
  assign fall = ~level_in & level_q;
endmodule

// File: rtl/pwd_blank_win.sv
module pwd_blank_win #(
  parameter int BLK_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [BLK_W-1:0] len,
  output logic             active
);
  logic [BLK_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= '0;
    else if (start)          remain <= len;
    else if (remain != '0)   remain <= remain - BLK_W'(1);
  end

  assign active = (remain != '0);
endmodule

// File: rtl/pwd_period_meter.sv
module pwd_period_meter #(
  parameter int CW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_rise,
  input  logic          quiet,
  input  logic [CW-1:0] short_lim,
  input  logic [CW-1:0] long_lim,
  output logic          armed,
  output logic [CW-1:0] elapsed,
  output logic          short_hit,
  output logic          long_hit,
  output logic          fault
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic fault_evt;

  assign short_hit = armed & valid_rise & (elapsed < short_lim);
  assign long_hit  = armed & ~valid_rise & quiet & (elapsed >= long_lim);
  assign fault_evt = short_hit | long_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      elapsed <= '0;
      fault   <= 1'b0;
    end else begin
      fault <= fault_evt;
      if (fault_evt) begin
        armed <= 1'b0;
      end else if (valid_rise) begin
        armed   <= 1'b1;
        elapsed <= CW'(1);
      end else if (armed && elapsed != CNT_MAX) begin
        elapsed <= elapsed + CW'(1);
      end
    end
  end
endmodule

// File: rtl/period_window_det.sv
module period_window_det #(
  parameter int CNT_W = 16,
  parameter int BLK_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_in,
  input  logic [CNT_W-1:0] nom_period,
  input  logic [BLK_W-1:0] blank_rise_len,
  input  logic [BLK_W-1:0] blank_fall_len,
  output logic             fault,
  output logic             blank_rise_act,
  output logic             blank_fall_act
);
  import pwd_pkg::*;

  localparam int CW     = CNT_W + 1;
  localparam int N_WIN  = 2;
  localparam int W_RISE = 0;
  localparam int W_FALL = 1;

  logic             raw_rise, raw_fall;
  logic             valid_rise, valid_fall, quiet;
  logic [CW-1:0]    short_lim, long_lim;
  logic             armed, short_hit, long_hit;
  logic [CW-1:0]    elapsed;
  logic [N_WIN-1:0] win_start, win_act;
  logic [BLK_W-1:0] win_len [N_WIN];

  assign short_lim = CW'(window_low(32'(nom_period)));
  assign long_lim  = CW'(window_high(32'(nom_period)));

  pwd_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .level_in(pwm_in),
    .rise(raw_rise), .fall(raw_fall)
  );

  assign quiet      = ~|win_act;
  assign valid_rise = raw_rise & quiet;
  assign valid_fall = raw_fall & quiet;

  assign win_start[W_RISE] = valid_rise;
  assign win_start[W_FALL] = valid_fall;
  assign win_len[W_RISE]   = blank_rise_len;
  assign win_len[W_FALL]   = blank_fall_len;

  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    pwd_blank_win #(.BLK_W(BLK_W)) u_win (
      .clk(clk), .rst_n(rst_n), .start(win_start[g]),
      .len(win_len[g]), .active(win_act[g])
    );
  end

  pwd_period_meter #(.CW(CW)) u_meter (
    .clk(clk), .rst_n(rst_n), .valid_rise(valid_rise), .quiet(quiet),
    .short_lim(short_lim), .long_lim(long_lim), .armed(armed),
    .elapsed(elapsed), .short_hit(short_hit), .long_hit(long_hit),
    .fault(fault)
  );

  assign blank_rise_act = win_act[W_RISE];
  assign blank_fall_act = win_act[W_FALL];
endmodule

// File: rtl/pwd_checker.sv
module pwd_checker #(
  parameter int CW = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fault,
  input logic          blank_rise_act,
  input logic          blank_fall_act,
  input logic          valid_rise,
  input logic          valid_fall,
  input logic          armed,
  input logic          short_hit,
  input logic          long_hit
);
  assert_fault_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault);

  assert_quiet_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_rise_act || blank_fall_act) |=> !fault);

  assert_idle_no_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !fault);

  assert_fault_disarms_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !armed);

  assert_rise_win_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blank_rise_act) |-> $past(valid_rise));

  assert_fall_win_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blank_fall_act) |-> $past(valid_fall));

  assert_short_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
    short_hit |=> fault);

  assert_long_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
    long_hit |=> fault);

  assert_edge_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_rise_act || blank_fall_act) |-> !(valid_rise || valid_fall));
endmodule

bind period_window_det pwd_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fault(fault),
  .blank_rise_act(blank_rise_act), .blank_fall_act(blank_fall_act),
  .valid_rise(valid_rise), .valid_fall(valid_fall), .armed(armed),
  .short_hit(short_hit), .long_hit(long_hit)
);

// File: tb/period_window_det_tb.sv
module period_window_det_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int BLK_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             pwm = 1'b0;
  logic [CNT_W-1:0] nom = 16'd100;
  logic [BLK_W-1:0] br_len = 8'd5;
  logic [BLK_W-1:0] bf_len = 8'd4;
  logic             fault, blank_rise_act, blank_fall_act;

  int compared = 0;
  int mismatched = 0;
  int fault_seen = 0;
  bit done = 1'b0;

  period_window_det #(.CNT_W(CNT_W), .BLK_W(BLK_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm), .nom_period(nom),
    .blank_rise_len(br_len), .blank_fall_len(bf_len),
    .fault(fault), .blank_rise_act(blank_rise_act), .blank_fall_act(blank_fall_act)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (fault) fault_seen++;

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  function automatic int ref_low(input int n);
    int k = 0;
    while (10 * (k + 1) <= 7 * n) k++;
    return k;
  endfunction

  function automatic int ref_high(input int n);
    int k = 0;
    while (10 * k < 13 * n) k++;
    return k;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    pwm = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);
    fault_seen = 0;
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    step(2);
    check("R1 fault in reset", int'(fault), 0);
    check("R1 rise window in reset", int'(blank_rise_act), 0);
    check("R1 fall window in reset", int'(blank_fall_act), 0);
    rst_n = 1'b1;
    step(300);
    check("R1 no fault without edges", fault_seen, 0);
    check("R1 rise window idle", int'(blank_rise_act), 0);
  endtask

  task automatic test_period(input int n, input int p);
    int lo = ref_low(n);
    int hi = ref_high(n);
    int exp = ((p < lo) || (p > hi)) ? 1 : 0;
    nom = CNT_W'(n); br_len = 8'd5; bf_len = 8'd4;
    do_reset();
    pwm = 1'b1; step(10);
    pwm = 1'b0; step(p - 10);
    pwm = 1'b1; step(2);
    check($sformatf("R2/R3/R4/R5 N=%0d P=%0d fault count", n, p), fault_seen, exp);
  endtask

  task automatic test_long_timing();
    nom = 16'd100; br_len = 8'd5; bf_len = 8'd4;
    do_reset();
    pwm = 1'b1; step(10);
    pwm = 1'b0; step(120);
    check("R3 no fault at k=130", int'(fault), 0);
    step(1);
    check("R3 fault at k=131", int'(fault), 1);
    pwm = 1'b1; step(1);
    check("R10 fault one cycle", int'(fault), 0);
    step(1);
    check("R9 first rise after fault", int'(fault), 0);
    check("R9 single fault seen", fault_seen, 1);
    step(7);
    pwm = 1'b0; step(41);
    pwm = 1'b1; step(1);
    check("R9 rearmed short fault", int'(fault), 1);
  endtask

  task automatic test_window();
    nom = 16'd100; br_len = 8'd5; bf_len = 8'd4;
    do_reset();
    pwm = 1'b1; step(1);
    check("R6 rise window k=1", int'(blank_rise_act), 1);
    pwm = 1'b0; step(1);
    check("R7 ignored fall k=2", int'(blank_fall_act), 0);
    pwm = 1'b1; step(1);
    check("R7 ignored fall k=3", int'(blank_fall_act), 0);
    step(2);
    check("R6 rise window k=5", int'(blank_rise_act), 1);
    step(1);
    check("R7 rise window not restarted k=6", int'(blank_rise_act), 0);
    step(24);
    pwm = 1'b0; step(1);
    check("R6 fall window k=31", int'(blank_fall_act), 1);
    step(3);
    check("R6 fall window k=34", int'(blank_fall_act), 1);
    step(1);
    check("R6 fall window closed k=35", int'(blank_fall_act), 0);
    step(35);
    pwm = 1'b1; step(1);
    check("R7 measurement kept, P=70 ok", int'(fault), 0);
    check("R6 new rise window", int'(blank_rise_act), 1);
    check("R7 no fault seen", fault_seen, 0);
  endtask

  task automatic test_defer();
    nom = 16'd10; br_len = 8'd2; bf_len = 8'd4;
    do_reset();
    pwm = 1'b1; step(11);
    pwm = 1'b0; step(3);
    check("R8 deferred k=14", int'(fault), 0);
    step(2);
    check("R8 deferred k=16", int'(fault), 0);
    step(1);
    check("R8 fault after window k=17", int'(fault), 1);
  endtask

  initial begin
    test_reset();
    test_period(100, 100);
    test_period(100, 70);
    test_period(100, 69);
    test_period(100, 130);
    test_period(100, 131);
    test_period(37, 25);
    test_period(37, 24);
    test_period(37, 49);
    test_period(37, 50);
    test_long_timing();
    test_window();
    test_defer();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog (R1-all run): actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule